// File: doc/BRIEF.md
# Memory-Device Test Access Port

This block is the boundary-scan test port of a memory device. A four-wire serial interface (test clock, mode select, serial data in, serial data out) plus an optional asynchronous reset drives a sixteen-state controller. The controller chooses between a 3-bit instruction register and one of three data registers: a single-bit bypass stage, a 32-bit device identification word, and a boundary scan register. The boundary scan register stands in for the device's input pins, its output pins, a shared output-enable control cell and a few cells that have no pin.

The block sits between the memory core and its pads. While in normal operation the pads carry the core's output data and enable. Under the external-test instruction the pads are driven from a separate update latch of the scan register. Under the high-impedance sample instruction every output driver is released. The input pins always reach the core unchanged, so the memory keeps following its pins even during external test. Test data is sampled on the rising test-clock edge. Serial output, instruction activation and the scan update latch all change on the falling edge.

Top module: `memtap_top`

## Requirements
- R1: When trst_n is low, or after five consecutive rising tck edges with tms high from any state, the controller is in Test-Logic-Reset and the active instruction is IDCODE. In that condition tdo_en is low and the pads carry core values.
- R2: Capture-IR loads 3'b001 into the instruction shift stage. Instruction bits are shifted in and out least significant bit first. The shifted value becomes active on the falling tck edge in Update-IR.
- R3: Under IDCODE (001), Capture-DR loads the identification word, which defaults to 32'h0B7051C3. Shift-DR presents it on tdo least significant bit first.
- R4: Under BYPASS (111) and the reserved codes 011, 101 and 110, a single bypass stage sits between tdi and tdo. It captures 0, so tdo repeats tdi one shift later.
- R5: Under EXTEST (000), SAMPLE-Z (010) and SAMPLE/PRELOAD (100), Capture-DR loads the 11-cell scan register. Bits [3:0] take pin_in_i, bits [7:4] take pad_out_o, bit 8 takes pad_oe_o and bits [10:9] take the fixed value 2'b10. Bit 0 is shifted out first. Under every instruction except 000 and 010, pad_out_o and pad_oe_o equal core_out_i and core_oe_i.
- R6: Under EXTEST, pad_out_o equals update-latch cells [7:4] and pad_oe_o equals latch cell 8. bsr_drive_o is high only under EXTEST.
- R7: Under SAMPLE-Z, pad_oe_o is low and the scan register is the selected data register.
- R8: core_in_o equals pin_in_i under every instruction, EXTEST included.
- R9: The update latch changes only on the falling tck edge in Update-DR while the scan register is selected. Shifting and pausing leave the pads untouched.
- R10: tdo_en is high only in Shift-IR and Shift-DR, and tdo is 0 while tdo_en is low. Both change on the falling tck edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in, sampled on rising tck |
| tdo | output | 1 | Serial test data out, changes on falling tck |
| tdo_en | output | 1 | High while tdo carries shift data |
| pin_in_i | input | N_IN | State of the device input pins |
| core_in_o | output | N_IN | Input pin values passed to the memory core |
| core_out_i | input | N_OUT | Output data the core wants on its pins |
| core_oe_i | input | 1 | Core output enable |
| pad_out_o | output | N_OUT | Data to the output drivers |
| pad_oe_o | output | 1 | Enable to the output drivers (0 = high-Z) |
| bsr_drive_o | output | 1 | High when the pads are driven from the scan update latch |

## Verification
A controller that lands in the wrong state shows up at once on tdo_en: it rises in a step where no shift should occur, or stays low during one. It also shows up one shift later as a wrong first bit on tdo. An instruction register that holds the wrong code is visible in the first step after Update-IR, through pad_oe_o, pad_out_o and bsr_drive_o. It is also visible in the length and contents of the next data shift, since the bypass, identification and scan registers each give a distinct bit pattern. A scan register or update latch with bad contents reaches the pads under EXTEST in the step after Update-DR. It reaches tdo during the next capture and shift.

// File: rtl/memtap_pkg.sv
package memtap_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;
    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_EXTEST  = 3'b000;
    localparam instr_t OP_IDCODE  = 3'b001;
    localparam instr_t OP_SAMPLEZ = 3'b010;
    localparam instr_t OP_SAMPLE  = 3'b100;
    localparam instr_t OP_BYPASS  = 3'b111;
    localparam instr_t IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} dr_sel_e;

    // Which data register sits between tdi and tdo; unlisted codes fall to bypass
    function automatic dr_sel_e dr_select(input instr_t op);
        dr_sel_e sel;
        case (op)
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: sel = DR_BOUNDARY;
            OP_IDCODE:                        sel = DR_IDENT;
            default:                          sel = DR_BYPASS;
        endcase
        return sel;
    endfunction

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
    import memtap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.st = tap_next(fsm_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) fsm_q <= '{st: ST_TLR};
        else         fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.st;

    // R1
    five_tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (fsm_q.st == ST_TLR));

endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
    import memtap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    output logic       tdo_o,
    output instr_t     active_o
);

    typedef struct packed {
        instr_t sh;
    } ir_pos_t;

    typedef struct packed {
        instr_t act;
    } ir_neg_t;

    ir_pos_t pos_d, pos_q;
    ir_neg_t neg_d, neg_q;

    always_comb begin
        pos_d = pos_q;
        case (state_i)
            ST_CAP_IR: pos_d.sh = IR_CAPTURE;
            ST_SH_IR:  pos_d.sh = {tdi, pos_q.sh[IR_W-1:1]};
            default:   pos_d.sh = pos_q.sh;
        endcase
    end

    always_comb begin
        neg_d = neg_q;
        if (state_i == ST_UPD_IR)   neg_d.act = pos_q.sh;
        else if (state_i == ST_TLR) neg_d.act = OP_IDCODE;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) pos_q <= '{sh: IR_CAPTURE};
        else         pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) neg_q <= '{act: OP_IDCODE};
        else         neg_q <= neg_d;
    end

    assign tdo_o    = pos_q.sh[0];
    assign active_o = neg_q.act;

    // R2
    ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_IR) |=> (pos_q.sh == IR_CAPTURE));

    // R1
    tlr_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_TLR) |-> (neg_q.act == OP_IDCODE));

endmodule

// File: rtl/memtap_bsr.sv
module memtap_bsr
    import memtap_pkg::*;
#(
    parameter int              N_IN       = 4,
    parameter int              N_OUT      = 4,
    parameter int              N_NC       = 2,
    parameter logic [N_NC-1:0] NC_DEFAULT = '0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_e       state_i,
    input  logic             sel_i,
    input  logic [N_IN-1:0]  pin_in_i,
    input  logic [N_OUT-1:0] pin_out_i,
    input  logic             pin_oe_i,
    output logic             tdo_o,
    output logic [N_OUT-1:0] upd_out_o,
    output logic             upd_oe_o
);

    localparam int LEN    = N_IN + N_OUT + 1 + N_NC;
    localparam int OUT_LO = N_IN;
    localparam int OE_POS = N_IN + N_OUT;
    localparam int UPD_W  = N_OUT + 1;

    typedef struct packed {
        logic [LEN-1:0] sh;
    } bsr_pos_t;

    typedef struct packed {
        logic [UPD_W-1:0] upd;
    } bsr_neg_t;

    bsr_pos_t pos_d, pos_q;
    bsr_neg_t neg_d, neg_q;

    logic [LEN-1:0] capture_vec;

    // Cell layout, bit 0 nearest tdo: inputs, outputs, enable cell, pinless cells
    always_comb begin
        capture_vec                = '0;
        capture_vec[N_IN-1:0]      = pin_in_i;
        capture_vec[OUT_LO +: N_OUT] = pin_out_i;
        capture_vec[OE_POS]        = pin_oe_i;
        capture_vec[LEN-1 -: N_NC] = NC_DEFAULT;
    end

    always_comb begin
        pos_d = pos_q;
        if (sel_i) begin
            if (state_i == ST_CAP_DR)     pos_d.sh = capture_vec;
            else if (state_i == ST_SH_DR) pos_d.sh = {tdi, pos_q.sh[LEN-1:1]};
        end
    end

    always_comb begin
        neg_d = neg_q;
        if (sel_i && state_i == ST_UPD_DR) neg_d.upd = pos_q.sh[OE_POS:OUT_LO];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) pos_q <= '0;
        else         pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) neg_q <= '0;
        else         neg_q <= neg_d;
    end

    assign tdo_o     = pos_q.sh[0];
    assign upd_out_o = neg_q.upd[N_OUT-1:0];
    assign upd_oe_o  = neg_q.upd[UPD_W-1];

    // R5
    bsr_capture_inputs_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sel_i && state_i == ST_CAP_DR) |=> (pos_q.sh[N_IN-1:0] == $past(pin_in_i)));

    // R9
    upd_latch_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(trst_n) && state_i != ST_UPD_DR) |-> $stable(neg_q.upd));

endmodule

// File: rtl/memtap_top.sv
module memtap_top
    import memtap_pkg::*;
#(
    parameter int              N_IN       = 4,
    parameter int              N_OUT      = 4,
    parameter int              N_NC       = 2,
    parameter logic [N_NC-1:0] NC_DEFAULT = 2'b10,
    parameter logic [31:0]     ID_VALUE   = 32'h0B7051C3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [N_IN-1:0]  pin_in_i,
    output logic [N_IN-1:0]  core_in_o,
    input  logic [N_OUT-1:0] core_out_i,
    input  logic             core_oe_i,
    output logic [N_OUT-1:0] pad_out_o,
    output logic             pad_oe_o,
    output logic             bsr_drive_o
);

    localparam int ID_W = 32;

    tap_state_e       state;
    instr_t           active;
    dr_sel_e          dr_sel;
    logic             ir_tdo;
    logic             bsr_tdo;
    logic             dr_tdo;
    logic [N_OUT-1:0] upd_out;
    logic             upd_oe;

    memtap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    memtap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state_i  (state),
        .tdo_o    (ir_tdo),
        .active_o (active)
    );

    assign dr_sel = dr_select(active);

    memtap_bsr #(
        .N_IN       (N_IN),
        .N_OUT      (N_OUT),
        .N_NC       (N_NC),
        .NC_DEFAULT (NC_DEFAULT)
    ) u_bsr (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state_i   (state),
        .sel_i     (dr_sel == DR_BOUNDARY),
        .pin_in_i  (pin_in_i),
        .pin_out_i (pad_out_o),
        .pin_oe_i  (pad_oe_o),
        .tdo_o     (bsr_tdo),
        .upd_out_o (upd_out),
        .upd_oe_o  (upd_oe)
    );

    // Bypass and identification stages
    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_regs_t;

    dr_regs_t dr_d, dr_q;

    always_comb begin
        dr_d = dr_q;
        if (dr_sel == DR_BYPASS) begin
            if (state == ST_CAP_DR)     dr_d.byp = 1'b0;
            else if (state == ST_SH_DR) dr_d.byp = tdi;
        end
        if (dr_sel == DR_IDENT) begin
            if (state == ST_CAP_DR)     dr_d.id = ID_VALUE;
            else if (state == ST_SH_DR) dr_d.id = {tdi, dr_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) dr_q <= '0;
        else         dr_q <= dr_d;
    end

    always_comb begin
        case (dr_sel)
            DR_IDENT:    dr_tdo = dr_q.id[0];
            DR_BOUNDARY: dr_tdo = bsr_tdo;
            default:     dr_tdo = dr_q.byp;
        endcase
    end

    // Serial output retimed to the falling edge
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    out_regs_t out_d, out_q;

    always_comb begin
        out_d.en  = (state == ST_SH_IR) || (state == ST_SH_DR);
        out_d.tdo = (state == ST_SH_IR) ? ir_tdo :
                    (state == ST_SH_DR) ? dr_tdo : 1'b0;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_en = out_q.en;

    // Pad drive selection
    always_comb begin
        bsr_drive_o = (active == OP_EXTEST);
        if (bsr_drive_o) begin
            pad_out_o = upd_out;
            pad_oe_o  = upd_oe;
        end else begin
            pad_out_o = core_out_i;
            pad_oe_o  = (active == OP_SAMPLEZ) ? 1'b0 : core_oe_i;
        end
    end

    assign core_in_o = pin_in_i;

    // R10
    tdo_en_shift_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R4
    bypass_capture_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_sel == DR_BYPASS && state == ST_CAP_DR) |=> (dr_q.byp == 1'b0));

    // R7
    samplez_release_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (active == OP_SAMPLEZ) |-> !pad_oe_o);

endmodule

// File: tb/memtap_top_tb_top.sv
`timescale 1ns/100ps
module memtap_top_tb_top;

    localparam int       N_IN    = 4;
    localparam int       N_OUT   = 4;
    localparam int       BSR_LEN = 11;
    localparam logic [1:0]  NC_DEF = 2'b10;
    localparam logic [31:0] ID_EXP = 32'h0B7051C3;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic             tdo;
    logic             tdo_en;
    logic [N_IN-1:0]  pin_in_i = '0;
    logic [N_IN-1:0]  core_in_o;
    logic [N_OUT-1:0] core_out_i = '0;
    logic             core_oe_i = 1'b0;
    logic [N_OUT-1:0] pad_out_o;
    logic             pad_oe_o;
    logic             bsr_drive_o;

    int errors = 0;
    int checks = 0;
    logic last_tdo;
    logic last_en;
    logic en_all;
    logic [N_OUT-1:0] lat_out = '0;
    logic             lat_oe = 1'b0;

    always #2.5 tck = ~tck;

    memtap_top dut_i (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_en      (tdo_en),
        .pin_in_i    (pin_in_i),
        .core_in_o   (core_in_o),
        .core_out_i  (core_out_i),
        .core_oe_i   (core_oe_i),
        .pad_out_o   (pad_out_o),
        .pad_oe_o    (pad_oe_o),
        .bsr_drive_o (bsr_drive_o)
    );

    // vector: op[11:9] pins[8:5] core_out[4:1] core_oe[0]
    localparam logic [11:0] VECS [8] = '{
        {3'b100, 4'b1010, 4'b0110, 1'b1},
        {3'b000, 4'b0101, 4'b1001, 1'b1},
        {3'b010, 4'b1100, 4'b0011, 1'b1},
        {3'b001, 4'b0011, 4'b1111, 1'b0},
        {3'b111, 4'b1111, 4'b0000, 1'b1},
        {3'b011, 4'b0110, 4'b1010, 1'b0},
        {3'b101, 4'b1001, 4'b0101, 1'b1},
        {3'b110, 4'b0001, 4'b1110, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        last_tdo = tdo;
        last_en  = tdo_en;
        tms = m;
        tdi = d;
    endtask

    task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        en_all = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step(k == 2, code[k]);
            cap[k] = last_tdo;
            en_all &= last_en;
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic shift_dr(input logic [63:0] din, input int len, output logic [63:0] dout,
                            input bit pause, input logic [N_OUT-1:0] pause_exp);
        dout = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        en_all = 1'b1;
        for (int k = 0; k < len; k++) begin
            step(k == len - 1, din[k]);
            dout[k] = last_tdo;
            en_all &= last_en;
        end
        if (pause) begin
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
            chk(pad_out_o === pause_exp, "R9 pads held during shift/pause", 64'(pad_out_o), 64'(pause_exp));
            step(1'b1, 1'b0);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout;
        logic [63:0] din;
        logic [63:0] exp_v;
        logic [10:0] exp_cap;
        logic [2:0]  op;
        int          len;
        string       tag;

        core_out_i = 4'b1011;
        core_oe_i  = 1'b1;
        pin_in_i   = 4'b0110;
        #12;
        // R1 reset state
        chk(tdo_en === 1'b0 && tdo === 1'b0, "R1 tdo idle in reset", 64'({tdo_en, tdo}), 64'd0);
        chk(pad_out_o === core_out_i && pad_oe_o === 1'b1 && bsr_drive_o === 1'b0,
            "R1 pads follow core in reset", 64'({bsr_drive_o, pad_oe_o, pad_out_o}), 64'({1'b0, 1'b1, core_out_i}));
        trst_n = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        shift_dr(64'h0, 32, dout, 1'b0, '0);
        chk(dout[31:0] === ID_EXP, "R1 R3 IDCODE default after reset", dout, 64'(ID_EXP));

        // Table walk over all eight opcodes
        for (int i = 0; i < 8; i++) begin
            op         = VECS[i][11:9];
            pin_in_i   = VECS[i][8:5];
            core_out_i = VECS[i][4:1];
            core_oe_i  = VECS[i][0];
            shift_ir(op, cap);
            chk(cap === 3'b001, "R2 capture-IR pattern", 64'(cap), 64'd1);
            chk(en_all === 1'b1, "R10 tdo_en high in Shift-IR", 64'(en_all), 64'd1);
            if (op == 3'b000) begin
                chk(pad_out_o === lat_out && pad_oe_o === lat_oe && bsr_drive_o === 1'b1,
                    "R6 EXTEST drives latch", 64'({bsr_drive_o, pad_oe_o, pad_out_o}), 64'({1'b1, lat_oe, lat_out}));
            end else if (op == 3'b010) begin
                chk(pad_oe_o === 1'b0 && pad_out_o === core_out_i && bsr_drive_o === 1'b0,
                    "R7 SAMPLE-Z releases drivers", 64'({bsr_drive_o, pad_oe_o, pad_out_o}), 64'({1'b0, 1'b0, core_out_i}));
            end else begin
                chk(pad_oe_o === core_oe_i && pad_out_o === core_out_i && bsr_drive_o === 1'b0,
                    "R5 pads follow core", 64'({bsr_drive_o, pad_oe_o, pad_out_o}), 64'({1'b0, core_oe_i, core_out_i}));
            end
            chk(core_in_o === pin_in_i, "R8 inputs reach core", 64'(core_in_o), 64'(pin_in_i));
            chk(tdo_en === 1'b0 && tdo === 1'b0, "R10 tdo idle in Run-Test/Idle", 64'({tdo_en, tdo}), 64'd0);

            exp_cap = {NC_DEF, pad_oe_o, pad_out_o, pin_in_i};
            din = 64'h9E3779B97F4A7C15 >> (i * 3);
            case (op)
                3'b000, 3'b010, 3'b100: begin len = BSR_LEN; exp_v = 64'(exp_cap); tag = "R5 boundary capture"; end
                3'b001:                 begin len = 32; exp_v = 64'(ID_EXP); tag = "R3 identification shift"; end
                default:                begin len = 8; exp_v = 64'({din[6:0], 1'b0}); tag = "R4 bypass delay"; end
            endcase
            shift_dr(din, len, dout, 1'b0, '0);
            chk((dout & ((64'd1 << len) - 1)) === exp_v, tag, dout, exp_v);
            chk(en_all === 1'b1, "R10 tdo_en high in Shift-DR", 64'(en_all), 64'd1);
            if (len == BSR_LEN) begin
                lat_out = din[N_IN +: N_OUT];
                lat_oe  = din[N_IN + N_OUT];
            end
            if (op == 3'b000)
                chk(pad_out_o === lat_out && pad_oe_o === lat_oe, "R6 EXTEST follows update",
                    64'({pad_oe_o, pad_out_o}), 64'({lat_oe, lat_out}));
            if (op == 3'b010)
                chk(pad_oe_o === 1'b0, "R7 SAMPLE-Z stays released", 64'(pad_oe_o), 64'd0);
        end

        // R9: preload, enter EXTEST, shift without disturbing pads
        core_out_i = 4'b0000;
        core_oe_i  = 1'b0;
        shift_ir(3'b100, cap);
        din = 64'h0000_0000_0000_05A0;
        shift_dr(din, BSR_LEN, dout, 1'b0, '0);
        chk(pad_out_o === 4'b0000, "R5 preload leaves pads on core", 64'(pad_out_o), 64'd0);
        shift_ir(3'b000, cap);
        chk(pad_out_o === 4'b1010 && pad_oe_o === 1'b1, "R6 preloaded value at Update-IR",
            64'({pad_oe_o, pad_out_o}), 64'({1'b1, 4'b1010}));
        pin_in_i = 4'b1110;
        #1;
        chk(core_in_o === 4'b1110, "R8 inputs pass through under EXTEST", 64'(core_in_o), 64'hE);
        din = 64'h0000_0000_0000_0050;
        shift_dr(din, BSR_LEN, dout, 1'b1, 4'b1010);
        chk(pad_out_o === 4'b0101 && pad_oe_o === 1'b0, "R9 latch written at Update-DR",
            64'({pad_oe_o, pad_out_o}), 64'({1'b0, 4'b0101}));

        // R1: five TMS-high edges from Shift-DR
        core_out_i = 4'b0111;
        core_oe_i  = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk(bsr_drive_o === 1'b0 && pad_out_o === 4'b0111, "R1 sync reset restores core drive",
            64'({bsr_drive_o, pad_out_o}), 64'({1'b0, 4'b0111}));
        step(1'b0, 1'b0);
        shift_dr(64'h0, 32, dout, 1'b0, '0);
        chk(dout[31:0] === ID_EXP, "R1 IDCODE after five TMS-high edges", dout, 64'(ID_EXP));

        // R1: asynchronous reset out of EXTEST
        shift_ir(3'b000, cap);
        chk(bsr_drive_o === 1'b1, "R6 EXTEST selected again", 64'(bsr_drive_o), 64'd1);
        trst_n = 1'b0;
        #1;
        chk(bsr_drive_o === 1'b0 && pad_oe_o === 1'b1 && pad_out_o === 4'b0111,
            "R1 async reset restores core drive", 64'({bsr_drive_o, pad_oe_o, pad_out_o}), 64'({1'b0, 1'b1, 4'b0111}));
        #12;
        trst_n = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        shift_ir(3'b111, cap);
        chk(cap === 3'b001, "R2 capture-IR after async reset", 64'(cap), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule